// File: doc/BRIEF.md
# Fractional-Ratio Serial Audio Master Clock Generator

This block produces the bit clock and the frame (word-select) clock for a serial audio port acting as clock master. It runs from one internal clock at twice the master-clock rate and offers two ratios. In the integer ratio a frame spans 256 internal cycles. In the fractional ratio the master clock is 125 times the frame rate, so a frame spans only 250 internal cycles. That does not split evenly into 64 bit periods.

To keep exactly 64 bit periods in every frame, the fractional ratio drops one low cycle from six bit periods in each frame. Those periods keep their full high phase, so their high phase is the longer one. An error accumulator picks the shortened periods so that they are spread evenly over the frame. Besides the two clocks, the block gives a serializer a one-cycle frame-start strobe and the index of the current bit. The ratio input is read only at frame boundaries.

Top module: `i2s_fclk_gen`

## Requirements
- R1: While `rst_i` is high, `sclk_o`, `lrck_o` and `frame_start_o` are 0 and `bit_idx_o` is 0.
- R2: In the first cycle after `rst_i` is sampled low, `frame_start_o` is 1 and `bit_idx_o` is 0, so frame 0 begins there.
- R3: With integer ratio (`frac_mode_i` = 0), every bit period is 2 cycles with `sclk_o` low followed by 2 cycles high, and a frame lasts 256 cycles.
- R4: With fractional ratio (`frac_mode_i` = 1), a frame lasts 250 cycles and still holds 64 bit periods.
- R5: In fractional ratio, bit b is shortened exactly when floor(6*(b+1)/64) differs from floor(6*b/64), which gives bits 10, 21, 31, 42, 53 and 63. A shortened bit has 1 low cycle and 2 high cycles. Every other bit has 2 low and 2 high.
- R6: `bit_idx_o` changes only in the cycle where `sclk_o` falls. It counts up by one and wraps from 63 to 0.
- R7: `lrck_o` is 0 during bits 0 to 31 and 1 during bits 32 to 63. It changes only in cycles where `sclk_o` is 0.
- R8: `frame_start_o` is 1 for exactly one cycle per frame: the first low cycle of bit 0.
- R9: `frac_mode_i` is sampled only when a new frame begins. A change in the middle of a frame leaves that frame's length and pattern unchanged and takes effect in the next frame.
- R10: In both ratios every high phase of `sclk_o` lasts exactly 2 cycles, which keeps the duty cycle between 50% and 67%.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the master-clock rate |
| rst_i | input | 1 | Synchronous reset, active high |
| frac_mode_i | input | 1 | 1 selects the fractional ratio (250 cycles per frame), 0 selects the integer ratio (256) |
| sclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Frame clock: 0 for the first half of the frame, 1 for the second |
| frame_start_o | output | 1 | One-cycle strobe in the first cycle of each frame |
| bit_idx_o | output | 6 | Index of the current bit within the frame, 0 to 63 |

## Verification
The hardest case to reach from the ports is a ratio change that arrives partway through a frame. The design must hold the old pattern for that frame and switch cleanly at the wrap. To reach it, the bench raises `frac_mode_i` so that one fractional frame starts, then flips the input to the integer ratio 100 cycles into that frame. It measures that frame and the next one cycle by cycle. The bench also records the low and high time of every bit separately, so a shortened period placed in the wrong bit is caught even when the frame length is still right.

// File: rtl/i2s_fclk_pkg.sv
`timescale 1ns/1ps
package i2s_fclk_pkg;

    // Clock-to-frame ratio selected for a frame
    typedef enum logic {
        RATIO_INT  = 1'b0,
        RATIO_FRAC = 1'b1
    } ratio_e;

endpackage

// File: rtl/i2s_fclk_spread.sv
`timescale 1ns/1ps
// Error accumulator that spreads shortened bit periods evenly over a frame.
module i2s_fclk_spread #(
    parameter int BITS   = 64,
    parameter int SHORTS = 6,
    parameter int ACC_W  = 7
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic             restart_i,
    input  logic             frac_i,
    output logic             short_o,
    output logic [ACC_W-1:0] acc_o
);
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] err;

    always_comb begin
        base = restart_i ? '0 : acc_i;
        err  = base + ACC_W'(SHORTS);
        if (frac_i && (err >= ACC_W'(BITS))) begin
            short_o = 1'b1;
            acc_o   = err - ACC_W'(BITS);
        end else begin
            short_o = 1'b0;
            acc_o   = frac_i ? err : '0;
        end
    end
endmodule

// File: rtl/i2s_fclk_phase.sv
`timescale 1ns/1ps
// Position inside one bit period: low phase first, then high phase.
module i2s_fclk_phase #(
    parameter int LOW_CYC  = 2,
    parameter int HIGH_CYC = 2,
    parameter int PH_W     = 2
) (
    input  logic [PH_W-1:0] ph_i,
    input  logic            short_i,
    output logic            last_o,
    output logic [PH_W-1:0] ph_next_o,
    output logic            sclk_next_o
);
    int ph_int;
    int low_len;

    always_comb begin
        ph_int  = int'(ph_i);
        low_len = short_i ? (LOW_CYC - 1) : LOW_CYC;
        last_o  = (ph_int == (low_len + HIGH_CYC - 1));
        if (last_o) begin
            ph_next_o   = '0;
            sclk_next_o = 1'b0;
        end else begin
            ph_next_o   = PH_W'(ph_int + 1);
            sclk_next_o = ((ph_int + 1) >= low_len);
        end
    end
endmodule

// File: rtl/i2s_fclk_frame.sv
`timescale 1ns/1ps
// Bit index advance, frame wrap and word-select level for the next bit.
module i2s_fclk_frame #(
    parameter int BITS  = 64,
    parameter int BIT_W = 6
) (
    input  logic [BIT_W-1:0] bit_i,
    input  logic             run_i,
    output logic             wrap_o,
    output logic [BIT_W-1:0] bit_next_o,
    output logic             lrck_next_o
);
    always_comb begin
        wrap_o      = !run_i || (int'(bit_i) == (BITS - 1));
        bit_next_o  = wrap_o ? '0 : (bit_i + BIT_W'(1));
        lrck_next_o = (int'(bit_next_o) >= (BITS / 2));
    end
endmodule

// File: rtl/i2s_fclk_gen.sv
`timescale 1ns/1ps
module i2s_fclk_gen
    import i2s_fclk_pkg::*;
#(
    parameter int BITS_PER_FRAME = 64,
    parameter int LOW_CYC        = 2,
    parameter int HIGH_CYC       = 2,
    parameter int FRAC_FRAME_CYC = 250
) (
    input  logic                              clk,
    input  logic                              rst_i,
    input  logic                              frac_mode_i,
    output logic                              sclk_o,
    output logic                              lrck_o,
    output logic                              frame_start_o,
    output logic [$clog2(BITS_PER_FRAME)-1:0] bit_idx_o
);
    localparam int NORM_LEN = LOW_CYC + HIGH_CYC;
    localparam int SHORTS   = BITS_PER_FRAME * NORM_LEN - FRAC_FRAME_CYC;
    localparam int BIT_W    = $clog2(BITS_PER_FRAME);
    localparam int PH_W     = $clog2(NORM_LEN);
    localparam int ACC_W    = $clog2(BITS_PER_FRAME + SHORTS + 1);

    typedef struct packed {
        logic             run;
        ratio_e           mode;
        logic [PH_W-1:0]  ph;
        logic [BIT_W-1:0] bitn;
        logic [ACC_W-1:0] acc;
        logic             shrt;
        logic             sclk;
        logic             lrck;
        logic             fstart;
    } gen_st_t;

    gen_st_t st_d, st_q;

    logic             ph_last;
    logic [PH_W-1:0]  ph_nxt;
    logic             sclk_nxt;
    logic             wrap;
    logic [BIT_W-1:0] bit_nxt;
    logic             lrck_nxt;
    ratio_e           mode_sel;
    logic             short_nxt;
    logic [ACC_W-1:0] acc_nxt;

    i2s_fclk_phase #(
        .LOW_CYC (LOW_CYC),
        .HIGH_CYC(HIGH_CYC),
        .PH_W    (PH_W)
    ) u_phase (
        .ph_i       (st_q.ph),
        .short_i    (st_q.shrt),
        .last_o     (ph_last),
        .ph_next_o  (ph_nxt),
        .sclk_next_o(sclk_nxt)
    );

    i2s_fclk_frame #(
        .BITS (BITS_PER_FRAME),
        .BIT_W(BIT_W)
    ) u_frame (
        .bit_i      (st_q.bitn),
        .run_i      (st_q.run),
        .wrap_o     (wrap),
        .bit_next_o (bit_nxt),
        .lrck_next_o(lrck_nxt)
    );

    always_comb begin
        mode_sel = wrap ? ratio_e'(frac_mode_i) : st_q.mode;
    end

    i2s_fclk_spread #(
        .BITS  (BITS_PER_FRAME),
        .SHORTS(SHORTS),
        .ACC_W (ACC_W)
    ) u_spread (
        .acc_i    (st_q.acc),
        .restart_i(wrap),
        .frac_i   (mode_sel == RATIO_FRAC),
        .short_o  (short_nxt),
        .acc_o    (acc_nxt)
    );

    always_comb begin
        st_d        = st_q;
        st_d.fstart = 1'b0;
        if (!st_q.run || ph_last) begin
            st_d.run    = 1'b1;
            st_d.mode   = mode_sel;
            st_d.ph     = '0;
            st_d.bitn   = bit_nxt;
            st_d.acc    = acc_nxt;
            st_d.shrt   = short_nxt;
            st_d.sclk   = 1'b0;
            st_d.lrck   = lrck_nxt;
            st_d.fstart = wrap;
        end else begin
            st_d.ph   = ph_nxt;
            st_d.sclk = sclk_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_i) begin
            st_q.run    <= 1'b0;
            st_q.mode   <= RATIO_INT;
            st_q.ph     <= '0;
            st_q.bitn   <= '0;
            st_q.acc    <= '0;
            st_q.shrt   <= 1'b0;
            st_q.sclk   <= 1'b0;
            st_q.lrck   <= 1'b0;
            st_q.fstart <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_o        = st_q.sclk;
    assign lrck_o        = st_q.lrck;
    assign frame_start_o = st_q.fstart;
    assign bit_idx_o     = st_q.bitn;

    AST_LRCK_SCLK_LOW: assert property (@(posedge clk) disable iff (rst_i)
        !$stable(st_q.lrck) |-> !st_q.sclk); // R7
    AST_HIGH_MIN_TWO: assert property (@(posedge clk) disable iff (rst_i)
        $rose(st_q.sclk) |=> st_q.sclk); // R10
    AST_HIGH_MAX_TWO: assert property (@(posedge clk) disable iff (rst_i)
        (st_q.sclk && $past(st_q.sclk)) |=> !st_q.sclk); // R10
    AST_SHORT_LOW_ONE: assert property (@(posedge clk) disable iff (rst_i)
        (st_q.run && st_q.shrt && !st_q.sclk) |=> st_q.sclk); // R5
    AST_INT_NO_SHORT: assert property (@(posedge clk) disable iff (rst_i)
        (st_q.mode == RATIO_INT) |-> !st_q.shrt); // R3
    AST_BIT_ON_FALL: assert property (@(posedge clk) disable iff (rst_i)
        !$stable(st_q.bitn) |-> !st_q.sclk); // R6
    AST_BIT_STEP: assert property (@(posedge clk) disable iff (rst_i)
        (st_q.run && $past(st_q.run) && !$stable(st_q.bitn)) |->
        (st_q.bitn == (($past(st_q.bitn) == BIT_W'(BITS_PER_FRAME - 1)) ?
                       BIT_W'(0) : ($past(st_q.bitn) + BIT_W'(1))))); // R6
    AST_FSTART_AT_BIT0: assert property (@(posedge clk) disable iff (rst_i)
        st_q.fstart |-> (st_q.bitn == '0 && !st_q.lrck && !st_q.sclk)); // R8
    AST_FSTART_SINGLE: assert property (@(posedge clk) disable iff (rst_i)
        st_q.fstart |=> !st_q.fstart); // R8
    AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst_i)
        (st_q.run && $past(st_q.run) && !$stable(st_q.mode)) |-> st_q.fstart); // R9
endmodule

// File: tb/i2s_fclk_gen_bench.sv
`timescale 1ns/1ps
module i2s_fclk_gen_bench;
    logic       clk = 1'b0;
    logic       rst_i = 1'b1;
    logic       frac_mode_i = 1'b0;
    logic       sclk_o, lrck_o, frame_start_o;
    logic [5:0] bit_idx_o;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    i2s_fclk_gen u_i2s_fclk_gen (
        .clk          (clk),
        .rst_i        (rst_i),
        .frac_mode_i  (frac_mode_i),
        .sclk_o       (sclk_o),
        .lrck_o       (lrck_o),
        .frame_start_o(frame_start_o),
        .bit_idx_o    (bit_idx_o)
    );

    // {ratio, expected frame cycles}
    localparam logic [9:0] VEC [6] = '{
        {1'b0, 9'd256}, {1'b1, 9'd250}, {1'b1, 9'd250},
        {1'b0, 9'd256}, {1'b1, 9'd250}, {1'b0, 9'd256}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit is_short(input bit frac, input int b);
        return frac && (((6 * (b + 1)) / 64) != ((6 * b) / 64));
    endfunction

    task automatic wait_fstart();
        int guard = 0;
        @(negedge clk);
        while (!frame_start_o && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // Entered at a negedge where frame_start_o is 1; returns at the next one.
    task automatic measure(input bit frac, input int exp_cyc, input int change_at,
                           input logic change_val);
        int lowc [64];
        int highc [64];
        int cyc = 0;
        int lr_bad = 0;
        int ord_bad = 0;
        int shape_bad = 0;
        int high_bad = 0;
        int bad_bit = -1;
        int prev_bit = 0;
        logic prev_lr = 1'b0;
        for (int i = 0; i < 64; i++) begin
            lowc[i] = 0;
            highc[i] = 0;
        end
        forever begin
            int b;
            b = int'(bit_idx_o);
            if (sclk_o) highc[b]++; else lowc[b]++;
            if (lrck_o != (b >= 32)) lr_bad++;
            if (cyc > 0) begin
                if (b != prev_bit && b != ((prev_bit + 1) % 64)) ord_bad++;
                if (b != prev_bit && sclk_o) ord_bad++;
                if (lrck_o != prev_lr && sclk_o) lr_bad++;
            end
            prev_bit = b;
            prev_lr = lrck_o;
            cyc++;
            if (cyc == change_at) frac_mode_i = change_val;
            @(negedge clk);
            if (frame_start_o || cyc > 400) break;
        end
        for (int i = 0; i < 64; i++) begin
            if (lowc[i] != (is_short(frac, i) ? 1 : 2)) begin
                shape_bad++;
                if (bad_bit < 0) bad_bit = i;
            end
            if (highc[i] != 2) high_bad++;
        end
        if (frac) begin
            check(cyc == exp_cyc, "R4 fractional frame length", cyc, exp_cyc);
            check(shape_bad == 0, "R5 shortened bit placement (first bad bit in actual)", bad_bit, -1);
        end else begin
            check(cyc == exp_cyc, "R3 integer frame length", cyc, exp_cyc);
            check(shape_bad == 0, "R3 integer bit shape (first bad bit in actual)", bad_bit, -1);
        end
        check(high_bad == 0, "R10 high phase two cycles", high_bad, 0);
        check(lr_bad == 0, "R7 lrck level and change point", lr_bad, 0);
        check(ord_bad == 0, "R6 bit index order", ord_bad, 0);
    endtask

    initial begin
        #(10 * 150000);
        nfail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(sclk_o == 1'b0, "R1 sclk in reset", sclk_o, 0);
        check(lrck_o == 1'b0, "R1 lrck in reset", lrck_o, 0);
        check(frame_start_o == 1'b0, "R1 frame_start in reset", frame_start_o, 0);
        check(bit_idx_o == 6'd0, "R1 bit index in reset", bit_idx_o, 0);
        rst_i = 1'b0;
        @(negedge clk);
        // R2: frame 0 begins in the first cycle after release
        check(frame_start_o == 1'b1, "R2 frame_start after release", frame_start_o, 1);
        check(bit_idx_o == 6'd0, "R2 bit index after release", bit_idx_o, 0);
        @(negedge clk);
        check(frame_start_o == 1'b0, "R8 strobe lasts one cycle", frame_start_o, 0);

        // Table walk
        for (int i = 0; i < 6; i++) begin
            frac_mode_i = VEC[i][9];
            wait_fstart();
            measure(VEC[i][9], int'(VEC[i][8:0]), -1, 1'b0);
        end

        // R9: mid-frame ratio change is deferred to the next frame
        frac_mode_i = 1'b1;
        wait_fstart();
        measure(1'b1, 250, 100, 1'b0); // R9 frame keeps fractional ratio
        measure(1'b0, 256, -1, 1'b0);  // R9 next frame uses integer ratio
        measure(1'b0, 256, 120, 1'b1); // R9 int frame unaffected by change
        measure(1'b1, 250, -1, 1'b1);

        // R1/R2: reset in the middle of a frame
        repeat (77) @(negedge clk);
        rst_i = 1'b1;
        @(negedge clk);
        check(sclk_o == 1'b0 && lrck_o == 1'b0, "R1 mid-frame reset clocks low",
              int'({sclk_o, lrck_o}), 0);
        check(bit_idx_o == 6'd0, "R1 mid-frame reset bit index", bit_idx_o, 0);
        frac_mode_i = 1'b1;
        rst_i = 1'b0;
        @(negedge clk);
        check(frame_start_o == 1'b1, "R2 restart after mid-frame reset", frame_start_o, 1);
        measure(1'b1, 250, -1, 1'b1); // R4 first frame after reset takes sampled ratio

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule